// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the polling status that a flash-style memory returns on reads while an internal program or erase runs. It owns bit 7 (the polling bit) and bit 5 (the limit-exceeded bit), and it tells the bus mode logic whether reads return array data or status. The command decoder pulses `start` on the rising edge of the last write-enable pulse of a program or erase sequence. With that pulse it supplies the operation type, bit 7 of the datum to be written, and whether the target is protected. For an erase, the protection flag means that every selected sector is protected.

For an unprotected target, the block follows the operation engine through its `eng_done` and `eng_timeout` strobes. For a protected target, the engine is not involved. Instead, a microsecond tick times a short pretend-busy window, and then the block drops back to array read. A timeout from the engine latches bit 5 until the decoder issues a reset command.

Top module: `poll_status_gen`

## Requirements
- R1: After reset, `array_read` is 1, `stat_b5` is 0 and `stat_b7` is 1.
- R2: A `start` accepted with `op_is_erase`=0 and `target_prot`=0 makes `stat_b7` the inverse of the captured `datum_b7` from the next cycle, with `array_read`=0. In the cycle after `eng_done`, `array_read` is 1 and `stat_b7` equals the captured datum.
- R3: A `start` accepted with `op_is_erase`=1 and `target_prot`=0 makes `stat_b7` 0 from the next cycle, with `array_read`=0. In the cycle after `eng_done`, `stat_b7` is 1 and `array_read` is 1.
- R4: While an erase is busy, `stat_b7` follows `erase_susp`: it is 1 while suspend is held and 0 otherwise, and `array_read` stays 0.
- R5: A program `start` during a busy erase is accepted only while `erase_susp` is 1. It then follows the same inverse/true rule as R2.
- R6: A protected program keeps `array_read` at 0 and `stat_b7` at the inverted datum. This lasts until PROT_PROG_US `us_tick` pulses (default 2) have been seen. In the cycle after the last of those pulses, `array_read` is 1. `eng_done` has no effect during that window.
- R7: A protected erase keeps `array_read` at 0 and `stat_b7` at 0 until PROT_ERASE_US `us_tick` pulses (default 100) have been seen. In the cycle after the last of those pulses, `array_read` is 1.
- R8: `eng_timeout` during a busy program or erase sets `stat_b5` to 1 in the next cycle. `eng_timeout` takes priority over `eng_done` in the same cycle. While bit 5 is set, `stat_b7` keeps its busy value and `array_read` stays 0. The state holds until `reset_cmd`, and the cycle after `reset_cmd` shows `stat_b5`=0 and `array_read`=1.
- R9: `start` is ignored while a program is busy, while a protected window runs, while bit 5 is set, and during an erase when suspend is not held or the new operation is an erase.
- R10: `reset_cmd` has no effect unless bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse at the end of a program or erase command sequence |
| op_is_erase | input | 1 | Operation type with `start`: 1 erase, 0 program |
| datum_b7 | input | 1 | Bit 7 of the datum being programmed, valid with `start` |
| target_prot | input | 1 | Target protected (for erase: all selected sectors protected) |
| erase_susp | input | 1 | Erase suspend is in force |
| eng_done | input | 1 | Operation engine finished |
| eng_timeout | input | 1 | Operation engine exceeded its internal time limit |
| reset_cmd | input | 1 | Reset command decoded |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| stat_b7 | output | 1 | Polling bit |
| stat_b5 | output | 1 | Limit-exceeded bit |
| array_read | output | 1 | 1 when reads return array data, 0 while status is returned |

## Verification
The assertions assume three things about the inputs. `start` is a single-cycle pulse. `datum_b7`, `op_is_erase` and `target_prot` are sampled only in the cycle that `start` is high. The engine strobes are meaningful only while a real operation runs. The stimulus drives all inputs from one sequencing process on the falling edge and holds `start` high for exactly one cycle. It deliberately raises `eng_done`, `start` and `reset_cmd` in states where they must be ignored. This lets the reference model and the assertions confirm that nothing moves.

// File: rtl/poll_status_pkg.sv
// Shared state encoding for the embedded operation status generator.
// Assumes: nothing beyond IEEE 1800-2017.
package poll_status_pkg;
    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,   // array read
        PS_PROG  = 3'd1,   // real program running
        PS_ERASE = 3'd2,   // real erase running (possibly suspended)
        PS_SHAM  = 3'd3,   // protected target, timed pretend-busy
        PS_FAIL  = 3'd4    // engine limit exceeded, waiting for reset command
    } poll_state_t;
endpackage

// File: rtl/poll_window_timer.sv
// Counts microsecond ticks while a protected-target window runs and
// flags the tick that ends it. Assumes limit >= 1 and stays stable while run is high.
module poll_window_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    // Purpose: clear on load, advance once per tick while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= '0;
        else if (run && tick)    cnt <= cnt + 1'b1;
    end

    // Purpose: the tick that brings the count to the limit ends the window.
    always_comb expire = run && tick && (cnt == limit - 1'b1);

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));
    assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (cnt <= $past(cnt) + 1'b1));
endmodule

// File: rtl/poll_fsm.sv
// Tracks which operation is in flight and what it targets.
// Assumes start is a single-cycle pulse with its qualifiers valid in that cycle.
module poll_fsm
    import poll_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_is_erase,
    input  logic        datum_b7,
    input  logic        target_prot,
    input  logic        erase_susp,
    input  logic        eng_done,
    input  logic        eng_timeout,
    input  logic        reset_cmd,
    input  logic        win_expire,
    output poll_state_t state,
    output logic        lat_erase,
    output logic        lat_datum,
    output logic        accept
);
    // Purpose: decide whether a start pulse may begin a new operation.
    always_comb begin
        accept = start && ((state == PS_IDLE) ||
                 ((state == PS_ERASE) && erase_susp && !op_is_erase));
    end

    // Purpose: state and operation capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_IDLE;
            lat_erase <= 1'b1;
            lat_datum <= 1'b1;
        end else begin
            if (accept) begin
                lat_erase <= op_is_erase;
                lat_datum <= datum_b7;
                if (target_prot)      state <= PS_SHAM;
                else if (op_is_erase) state <= PS_ERASE;
                else                  state <= PS_PROG;
            end else begin
                case (state)
                    PS_PROG, PS_ERASE: begin
                        if (eng_timeout)   state <= PS_FAIL;
                        else if (eng_done) state <= PS_IDLE;
                    end
                    PS_SHAM: if (win_expire) state <= PS_IDLE;
                    PS_FAIL: if (reset_cmd)  state <= PS_IDLE;
                    default: ;
                endcase
            end
        end
    end

    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_FAIL && !reset_cmd) |=> (state == PS_FAIL));
    assert_sham_ignores_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SHAM && !win_expire) |=> (state == PS_SHAM));
endmodule

// File: rtl/poll_status_encode.sv
// Turns the operation state into the status bits seen on the data bus.
// Assumes lat_erase/lat_datum describe the latest accepted operation.
module poll_status_encode
    import poll_status_pkg::*;
(
    input  poll_state_t state,
    input  logic        lat_erase,
    input  logic        lat_datum,
    input  logic        erase_susp,
    output logic        stat_b7,
    output logic        stat_b5,
    output logic        array_read
);
    logic busy_b7;

    // Purpose: value the polling bit shows while an operation is pending.
    always_comb busy_b7 = lat_erase ? 1'b0 : ~lat_datum;

    // Purpose: select the bus-visible status for each state.
    always_comb begin
        stat_b5    = (state == PS_FAIL);
        array_read = (state == PS_IDLE);
        case (state)
            PS_IDLE:  stat_b7 = lat_erase ? 1'b1 : lat_datum;
            PS_PROG:  stat_b7 = ~lat_datum;
            PS_ERASE: stat_b7 = erase_susp;
            default:  stat_b7 = busy_b7;
        endcase
    end
endmodule

// File: rtl/poll_status_gen.sv
// Top of the embedded operation status generator: wires the state tracker,
// the protected-window timer and the status encoder.
// Assumes us_tick is a one-cycle pulse once per microsecond.
module poll_status_gen
    import poll_status_pkg::*;
#(
    parameter int PROT_PROG_US  = 2,
    parameter int PROT_ERASE_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_is_erase,
    input  logic datum_b7,
    input  logic target_prot,
    input  logic erase_susp,
    input  logic eng_done,
    input  logic eng_timeout,
    input  logic reset_cmd,
    input  logic us_tick,
    output logic stat_b7,
    output logic stat_b5,
    output logic array_read
);
    localparam int MAXW = (PROT_PROG_US > PROT_ERASE_US) ? PROT_PROG_US : PROT_ERASE_US;
    localparam int CW   = $clog2(MAXW + 1);

    poll_state_t   state;
    logic          lat_erase, lat_datum, accept, win_expire;
    logic [CW-1:0] win_limit;

    // Purpose: pick the window length for the captured operation type.
    always_comb win_limit = lat_erase ? CW'(PROT_ERASE_US) : CW'(PROT_PROG_US);

    poll_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op_is_erase(op_is_erase),
        .datum_b7(datum_b7), .target_prot(target_prot), .erase_susp(erase_susp),
        .eng_done(eng_done), .eng_timeout(eng_timeout), .reset_cmd(reset_cmd),
        .win_expire(win_expire), .state(state), .lat_erase(lat_erase),
        .lat_datum(lat_datum), .accept(accept)
    );

    poll_window_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(accept), .run(state == PS_SHAM),
        .tick(us_tick), .limit(win_limit), .expire(win_expire)
    );

    poll_status_encode u_enc (
        .state(state), .lat_erase(lat_erase), .lat_datum(lat_datum),
        .erase_susp(erase_susp), .stat_b7(stat_b7), .stat_b5(stat_b5),
        .array_read(array_read)
    );

    assert_prog_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_is_erase && !target_prot && array_read) |=>
        (stat_b7 == !$past(datum_b7) && !array_read));
    assert_erase_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_is_erase && !target_prot && array_read) |=>
        (stat_b7 == erase_susp && !array_read));
    assert_b5_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b5 && !reset_cmd) |=> stat_b5);
    assert_b5_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_b5 |-> !array_read);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (array_read && !stat_b5 && stat_b7));
endmodule

// File: tb/poll_status_gen_bench.sv
module poll_status_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, op_is_erase = 0, datum_b7 = 0, target_prot = 0;
    logic erase_susp = 0, eng_done = 0, eng_timeout = 0, reset_cmd = 0, us_tick = 0;
    logic stat_b7, stat_b5, array_read;

    int checks = 0, failures = 0, tick_ctr = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 program, 2 erase, 3 protected window, 4 limit hit
    int  m_mode = 0;
    bit  m_erase = 1, m_datum = 1;
    int  m_ticks = 0;

    always #4 clk = ~clk;

    poll_status_gen u_poll_status_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .op_is_erase(op_is_erase),
        .datum_b7(datum_b7), .target_prot(target_prot), .erase_susp(erase_susp),
        .eng_done(eng_done), .eng_timeout(eng_timeout), .reset_cmd(reset_cmd),
        .us_tick(us_tick), .stat_b7(stat_b7), .stat_b5(stat_b5), .array_read(array_read)
    );

    always @(posedge clk) begin
        bit take;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_erase = 1; m_datum = 1; m_ticks = 0;
        end else begin
            take = start && (m_mode == 0 || (m_mode == 2 && erase_susp && !op_is_erase));
            if (take) begin
                m_erase = op_is_erase; m_datum = datum_b7; m_ticks = 0;
                m_mode  = target_prot ? 3 : (op_is_erase ? 2 : 1);
            end else if (m_mode == 1 || m_mode == 2) begin
                if (eng_timeout)   m_mode = 4;
                else if (eng_done) m_mode = 0;
            end else if (m_mode == 3) begin
                if (us_tick) begin
                    m_ticks++;
                    if (m_ticks == (m_erase ? 100 : 2)) m_mode = 0;
                end
            end else if (m_mode == 4) begin
                if (reset_cmd) m_mode = 0;
            end
        end
    end

    task automatic compare();
        bit e7, e5, ea;
        ea = (m_mode == 0);
        e5 = (m_mode == 4);
        if (m_mode == 0)      e7 = m_erase ? 1'b1 : m_datum;
        else if (m_mode == 2) e7 = erase_susp;
        else                  e7 = m_erase ? 1'b0 : !m_datum;
        checks++;
        if (stat_b7 !== e7 || stat_b5 !== e5 || array_read !== ea) begin
            failures++;
            $display("FAIL %s: b7/b5/array_read actual=%b%b%b expected=%b%b%b",
                     cur_req, stat_b7, stat_b5, array_read, e7, e5, ea);
        end
    endtask

    // one cycle: check outputs at the falling edge, then advance the tick stream
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            tick_ctr++;
            us_tick = (tick_ctr % 4 == 0);
        end
    endtask

    task automatic go(bit er, bit d, bit prot);
        op_is_erase = er; datum_b7 = d; target_prot = prot; start = 1;
        cyc();
        start = 0; op_is_erase = 0; datum_b7 = 0; target_prot = 0;
    endtask

    task automatic pulse_done();  eng_done = 1; cyc(); eng_done = 0; endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; cyc(2);
        // R2: program both datum polarities
        cur_req = "R2"; go(0, 1, 0); cyc(4); pulse_done(); cyc(2);
        go(0, 0, 0); cyc(3); pulse_done(); cyc(2);
        // R3: erase
        cur_req = "R3"; go(1, 0, 0); cyc(4); pulse_done(); cyc(2);
        // R4: suspend toggling within erase
        cur_req = "R4"; go(1, 0, 0); cyc(2); erase_susp = 1; cyc(3); erase_susp = 0; cyc(2);
        // R5: program accepted during suspend, erase start refused during suspend
        cur_req = "R5"; erase_susp = 1; go(1, 1, 0); cyc(1);
        go(0, 1, 0); cyc(3); erase_susp = 0; pulse_done(); cyc(2);
        // R9: program refused during unsuspended erase, then finish erase
        cur_req = "R9"; go(1, 0, 0); go(0, 0, 0); cyc(2); pulse_done(); cyc(1);
        // R6: protected program, done ignored, start ignored
        cur_req = "R6"; go(0, 0, 1); cyc(1); pulse_done(); go(1, 1, 0); cyc(12);
        // R7: protected erase
        cur_req = "R7"; go(1, 0, 1); cyc(420);
        // R9: start refused while a program is busy
        cur_req = "R9"; go(0, 1, 0); go(0, 0, 0); cyc(2); pulse_done(); cyc(1);
        // R10: reset command ignored in idle and while busy
        cur_req = "R10"; reset_cmd = 1; cyc(2); go(0, 1, 0); cyc(2); reset_cmd = 0;
        pulse_done(); cyc(1);
        // R8: timeout sticks, wins over done, ignores start, cleared by reset command
        cur_req = "R8"; go(0, 1, 0); cyc(2); eng_timeout = 1; eng_done = 1; cyc();
        eng_timeout = 0; eng_done = 0; cyc(3); go(1, 0, 0); pulse_done(); cyc(2);
        reset_cmd = 1; cyc(); reset_cmd = 0; cyc(2);
        go(1, 0, 0); eng_timeout = 1; cyc(); eng_timeout = 0; cyc(3);
        reset_cmd = 1; cyc(); reset_cmd = 0; cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule